// File: doc/BRIEF.md
# Spatial region generation tracker

This block watches the demand accesses of a first-level cache and keeps a small set-associative table of regions that are currently being touched. Each region is a fixed, power-of-two slice of the address space, split into cache lines. The first access to a region that has no live entry opens a new entry, called a generation. The entry keeps the program counter of that opening access, the physical region number and a record of which lines of the region were used. Later accesses to the same region add their lines to the record.

Before every lookup the block walks the whole table and asks the cache, through a probe port, whether each recorded line is still resident in the cache or its miss queue. When one of them has left both, the generation is over. The block then emits a pattern record, keyed by the opening program counter shifted left by the region's address bits plus the line offset that was found missing, and frees the entry. A new access is held off by a ready signal while this walk and the following table update are under way.

Each recorded line also carries a small gap count. Every entry counts the accesses that went to other entries since its own last access, and a newly recorded line stores that count. The pattern record carries the line mask and these gap counts.

Top module: `region_gen_tracker`

## Requirements
- R1: An access carries a virtual line address (virtual byte address divided by the line size) and a physical region number. The region number is the line address shifted right by log2(lines per region), the line offset is its low log2(lines per region) bits, and the set is the low bits of the region number. The probe address of a recorded line is physical region number times region size plus offset times line size.
- R2: An access presented without a valid program counter is accepted with ready staying high, starts no probe, emits no pattern and leaves the table unchanged.
- R3: A lookup miss allocates the lowest-numbered invalid way of the set, or the least recently used way when all four are valid; the old contents of a replaced way are dropped with no pattern. The new entry holds the program counter, the physical region, the security bit and only the first offset, with gap 0.
- R4: A lookup hit on a line not yet recorded sets that line's bit in the mask and stores the entry's current gap count as that line's gap; a hit on a line already recorded changes neither. Every access to an entry clears the entry's gap count.
- R5: On each applied access, every other valid entry's gap count rises by one and saturates at its maximum (15 at the default width).
- R6: Before the lookup, entries are visited in ascending index (set times ways plus way) and lines in ascending offset; one probe is raised for each recorded line of each valid entry, holding its address and security bit until the response is taken in a cycle with probe_valid high.
- R7: A probe answered with probe_hit low ends that generation: in the next cycle pat_valid is high for one record with key = (program counter << log2(region bytes)) + offset of the missing line, plus the entry's line mask (bit i = offset i) and gap counts (bits 4i+3..4i = offset i), the entry is freed and its remaining lines are not probed.
- R8: Ready drops in the cycle after an access with a valid program counter is accepted and returns high only once the walk and the table update are complete; no probe is raised while ready is high.
- R9: After reset ready is high, no probe or pattern is raised and the table is empty.
- R10: An entry freed by the walk of an access is not hit by that same access's lookup; an access to the same region opens a fresh generation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access offered |
| acc_ready | output | 1 | Block can take an access |
| acc_pc_valid | input | 1 | Program counter of the access is meaningful |
| acc_pc | input | PC_W | Program counter |
| acc_vline | input | ADDR_W-log2(LINE_BYTES) | Virtual line address |
| acc_pregion | input | ADDR_W-log2(REGION_BYTES) | Physical region number |
| acc_secure | input | 1 | Security space of the access |
| probe_req | output | 1 | Residency question pending |
| probe_addr | output | ADDR_W | Physical byte address of the probed line |
| probe_secure | output | 1 | Security space of the probed line |
| probe_valid | input | 1 | Residency answer present |
| probe_hit | input | 1 | Line is in the cache or its miss queue |
| pat_valid | output | 1 | Pattern record present |
| pat_key | output | PC_W+log2(REGION_BYTES) | Program counter and trigger offset key |
| pat_lines | output | LINES | Mask of lines recorded in the generation |
| pat_deltas | output | LINES*DELTA_W | Gap count of each recorded line |

## Verification
The two functions that meet within one access are the closing of a generation by the residency walk and the lookup for the same region that follows it. The bench arranges that the physical lines of an open region are reported missing at the moment a new access to that very region arrives, then checks that a pattern with the old program counter comes out and that the access opens a fresh entry instead of extending the freed one, which a later forced close reveals through its key and single-line mask. The same walk also mixes a closed entry with a still-resident one, so the probe order and the skipped lines of the closed entry are judged from the probe log.

// File: rtl/region_gen_tracker.sv
module region_gen_tracker #(
  parameter int ADDR_W       = 32,
  parameter int PC_W         = 16,
  parameter int REGION_BYTES = 256,
  parameter int LINE_BYTES   = 64,
  parameter int SETS         = 2,
  parameter int WAYS         = 4,
  parameter int DELTA_W      = 4
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        acc_valid,
  output logic                                        acc_ready,
  input  logic                                        acc_pc_valid,
  input  logic [PC_W-1:0]                             acc_pc,
  input  logic [ADDR_W-$clog2(LINE_BYTES)-1:0]        acc_vline,
  input  logic [ADDR_W-$clog2(REGION_BYTES)-1:0]      acc_pregion,
  input  logic                                        acc_secure,
  output logic                                        probe_req,
  output logic [ADDR_W-1:0]                           probe_addr,
  output logic                                        probe_secure,
  input  logic                                        probe_valid,
  input  logic                                        probe_hit,
  output logic                                        pat_valid,
  output logic [PC_W+$clog2(REGION_BYTES)-1:0]        pat_key,
  output logic [REGION_BYTES/LINE_BYTES-1:0]          pat_lines,
  output logic [(REGION_BYTES/LINE_BYTES)*DELTA_W-1:0] pat_deltas
);
  localparam int RB_W    = $clog2(REGION_BYTES);
  localparam int LN_W    = $clog2(LINE_BYTES);
  localparam int OFF_W   = RB_W - LN_W;
  localparam int LINES   = 1 << OFF_W;
  localparam int RGN_W   = ADDR_W - RB_W;
  localparam int VL_W    = ADDR_W - LN_W;
  localparam int SET_W   = $clog2(SETS);
  localparam int WAY_W   = $clog2(WAYS);
  localparam int TAG_W   = RGN_W - SET_W;
  localparam int ENTRIES = SETS * WAYS;
  localparam int E_W     = $clog2(ENTRIES);
  localparam logic [DELTA_W-1:0] DMAX = '1;

  if ((REGION_BYTES & (REGION_BYTES - 1)) != 0 || (LINE_BYTES & (LINE_BYTES - 1)) != 0 ||
      (SETS & (SETS - 1)) != 0 || (WAYS & (WAYS - 1)) != 0 || SETS < 2 || LINE_BYTES >= REGION_BYTES)
    $error("sizes must be powers of two, SETS >= 2, lines smaller than regions");

  typedef enum logic [1:0] {IDLE, SCAN, APPLY} st_t;
  st_t st;

  logic [ENTRIES-1:0]         vld, sec;
  logic [TAG_W-1:0]           tag   [ENTRIES];
  logic [PC_W-1:0]            epc   [ENTRIES];
  logic [RGN_W-1:0]           pbase [ENTRIES];
  logic [LINES-1:0]           lmask [ENTRIES];
  logic [LINES*DELTA_W-1:0]   dlt   [ENTRIES];
  logic [DELTA_W-1:0]         seqc  [ENTRIES];
  logic [WAY_W-1:0]           age   [ENTRIES];

  logic [PC_W-1:0]  a_pc;
  logic [VL_W-1:0]  a_vl;
  logic [RGN_W-1:0] a_pr;
  logic             a_sec;
  logic [E_W-1:0]   cur_e;
  logic [OFF_W-1:0] cur_l;

  wire [SET_W-1:0] a_set = a_vl[OFF_W +: SET_W];
  wire [TAG_W-1:0] a_tag = a_vl[VL_W-1:OFF_W+SET_W];
  wire [OFF_W-1:0] a_off = a_vl[OFF_W-1:0];

  wire cand  = vld[cur_e] && lmask[cur_e][cur_l];
  wire ended = probe_req && probe_valid && !probe_hit;
  wire step  = (st == SCAN) && (!cand || probe_valid);
  wire nxt_e = ended || (cur_l == OFF_W'(LINES - 1));

  assign acc_ready    = (st == IDLE);
  assign probe_req    = (st == SCAN) && cand;
  assign probe_addr   = {pbase[cur_e], cur_l, {LN_W{1'b0}}};
  assign probe_secure = sec[cur_e];

  logic             hit, inv_ok;
  logic [WAY_W-1:0] hit_way, inv_way, lru_way, tgt_way;
  logic [E_W-1:0]   lk;

  always_comb begin
    hit = 1'b0; inv_ok = 1'b0;
    hit_way = '0; inv_way = '0; lru_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      lk = {a_set, WAY_W'(w)};
      if (!vld[lk]) begin
        inv_ok = 1'b1; inv_way = WAY_W'(w);
      end else if (tag[lk] == a_tag && sec[lk] == a_sec) begin
        hit = 1'b1; hit_way = WAY_W'(w);
      end
      if (age[lk] == WAY_W'(WAYS - 1)) lru_way = WAY_W'(w);
    end
  end

  assign tgt_way = hit ? hit_way : (inv_ok ? inv_way : lru_way);
  wire [E_W-1:0] tgt = {a_set, tgt_way};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; cur_e <= '0; cur_l <= '0;
      a_pc <= '0; a_vl <= '0; a_pr <= '0; a_sec <= 1'b0;
      vld <= '0; sec <= '0;
      pat_valid <= 1'b0; pat_key <= '0; pat_lines <= '0; pat_deltas <= '0;
      for (int e = 0; e < ENTRIES; e++) begin
        tag[e] <= '0; epc[e] <= '0; pbase[e] <= '0; lmask[e] <= '0;
        dlt[e] <= '0; seqc[e] <= '0; age[e] <= WAY_W'(e % WAYS);
      end
    end else begin
      pat_valid <= ended;
      if (ended) begin
        pat_key    <= {epc[cur_e], {(RB_W-OFF_W){1'b0}}, cur_l};
        pat_lines  <= lmask[cur_e];
        pat_deltas <= dlt[cur_e];
        vld[cur_e] <= 1'b0;
      end
      case (st)
        IDLE: if (acc_valid && acc_pc_valid) begin
          a_pc <= acc_pc; a_vl <= acc_vline; a_pr <= acc_pregion; a_sec <= acc_secure;
          cur_e <= '0; cur_l <= '0; st <= SCAN;
        end
        SCAN: if (step) begin
          if (nxt_e) begin
            cur_l <= '0;
            cur_e <= cur_e + 1'b1;
            if (cur_e == E_W'(ENTRIES - 1)) st <= APPLY;
          end else begin
            cur_l <= cur_l + 1'b1;
          end
        end
        APPLY: begin
          st <= IDLE;
          for (int e = 0; e < ENTRIES; e++)
            if (E_W'(e) != tgt && vld[e] && seqc[e] != DMAX) seqc[e] <= seqc[e] + 1'b1;
          for (int w = 0; w < WAYS; w++)
            if (WAY_W'(w) == tgt_way) age[{a_set, WAY_W'(w)}] <= '0;
            else if (age[{a_set, WAY_W'(w)}] < age[tgt])
              age[{a_set, WAY_W'(w)}] <= age[{a_set, WAY_W'(w)}] + 1'b1;
          seqc[tgt] <= '0;
          if (hit) begin
            if (!lmask[tgt][a_off]) begin
              lmask[tgt][a_off] <= 1'b1;
              dlt[tgt][a_off*DELTA_W +: DELTA_W] <= seqc[tgt];
            end
          end else begin
            vld[tgt] <= 1'b1; sec[tgt] <= a_sec;
            tag[tgt] <= a_tag; epc[tgt] <= a_pc; pbase[tgt] <= a_pr;
            lmask[tgt] <= LINES'(1) << a_off;
            dlt[tgt] <= '0;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/region_gen_tracker_chk.sv
module region_gen_tracker_chk #(
  parameter int ADDR_W       = 32,
  parameter int PC_W         = 16,
  parameter int REGION_BYTES = 256,
  parameter int LINE_BYTES   = 64
) (
  input logic                                   clk,
  input logic                                   rst_n,
  input logic                                   acc_valid,
  input logic                                   acc_ready,
  input logic                                   acc_pc_valid,
  input logic                                   probe_req,
  input logic [ADDR_W-1:0]                      probe_addr,
  input logic                                   probe_valid,
  input logic                                   probe_hit,
  input logic                                   pat_valid,
  input logic [PC_W+$clog2(REGION_BYTES)-1:0]   pat_key,
  input logic [REGION_BYTES/LINE_BYTES-1:0]     pat_lines
);
  localparam int RB_W  = $clog2(REGION_BYTES);
  localparam int OFF_W = RB_W - $clog2(LINE_BYTES);

  p_nopc_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_ready && !acc_pc_valid |=> acc_ready);

  p_probe_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    probe_req && !probe_valid |=> probe_req && $stable(probe_addr));

  p_pat_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pat_valid |-> $past(probe_req && probe_valid && !probe_hit));

  p_pat_shape_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pat_valid |-> pat_key[RB_W-1:OFF_W] == '0 && pat_lines != '0);

  p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_ready && acc_pc_valid |=> !acc_ready);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ready |-> !probe_req);

  p_reset_out_r9: assert property (@(posedge clk)
    !rst_n |=> acc_ready && !pat_valid && !probe_req);
endmodule

bind region_gen_tracker region_gen_tracker_chk #(
  .ADDR_W(ADDR_W), .PC_W(PC_W), .REGION_BYTES(REGION_BYTES), .LINE_BYTES(LINE_BYTES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
  .acc_pc_valid(acc_pc_valid), .probe_req(probe_req), .probe_addr(probe_addr),
  .probe_valid(probe_valid), .probe_hit(probe_hit), .pat_valid(pat_valid),
  .pat_key(pat_key), .pat_lines(pat_lines)
);

// File: tb/region_gen_tracker_test.sv
`timescale 1ns/1ps
module region_gen_tracker_test;
  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, acc_pc_valid = 0, acc_secure = 0;
  logic [15:0] acc_pc = 0;
  logic [25:0] acc_vline = 0;
  logic [23:0] acc_pregion = 0;
  logic acc_ready, probe_req, probe_secure, probe_valid, probe_hit, pat_valid;
  logic [31:0] probe_addr;
  logic [23:0] pat_key;
  logic [3:0]  pat_lines;
  logic [15:0] pat_deltas;

  logic miss_all = 0, miss_en = 0;
  logic [23:0] miss_rgn = 0;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  region_gen_tracker uut (.*);

  assign probe_valid = probe_req;
  assign probe_hit = !(miss_all || (miss_en && probe_addr[31:8] == miss_rgn));

  int np = 0, nq = 0;
  logic [31:0] plog_a [64];
  logic        plog_s [64];
  logic [23:0] qk [16];
  logic [3:0]  ql [16];
  logic [15:0] qd [16];

  always @(posedge clk) begin
    if (probe_req && probe_valid) begin
      plog_a[np % 64] <= probe_addr; plog_s[np % 64] <= probe_secure; np <= np + 1;
    end
    if (pat_valid) begin
      qk[nq % 16] <= pat_key; ql[nq % 16] <= pat_lines; qd[nq % 16] <= pat_deltas; nq <= nq + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  bit busy_seen;
  task automatic access(input logic [15:0] pc, input bit pcv, input bit s,
                        input logic [31:0] va, input logic [31:0] pa);
    @(negedge clk);
    acc_valid = 1; acc_pc_valid = pcv; acc_pc = pc; acc_secure = s;
    acc_vline = va[31:6]; acc_pregion = pa[31:8];
    @(posedge clk);
    @(negedge clk);
    acc_valid = 0;
    busy_seen = !acc_ready;
    while (!acc_ready) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  localparam int NV = 5;
  localparam logic [15:0] VPC [NV] = '{16'h11, 16'h12, 16'h13, 16'h14, 16'h15};
  localparam logic [31:0] VVA [NV] = '{32'h1000, 32'h1040, 32'h1180, 32'h10C0, 32'h1040};
  localparam logic [31:0] VPA [NV] = '{32'h8000, 32'h8040, 32'h9180, 32'h80C0, 32'h8040};
  localparam bit          VSC [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
  localparam int          VNP [NV] = '{0, 1, 2, 3, 4};

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int p0, q0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(acc_ready == 1, "R9", "ready after reset", acc_ready, 1);
    chk(probe_req == 0 && pat_valid == 0, "R9", "probe/pattern idle", {probe_req, pat_valid}, 0);

    for (int i = 0; i < NV; i++) begin
      p0 = np;
      access(VPC[i], 1, VSC[i], VVA[i], VPA[i]);
      chk(np - p0 == VNP[i], "R6", "probes per access", np - p0, VNP[i]);
      chk(busy_seen, "R8", "ready low during walk", !busy_seen, 0);
      if (i == 1) chk(plog_a[p0 % 64] == 32'h8000, "R1", "probe address", plog_a[p0 % 64], 32'h8000);
    end
    chk(nq == 0, "R6", "no pattern while resident", nq, 0);

    miss_rgn = 24'h80; miss_en = 1;
    p0 = np; q0 = nq;
    access(16'h20, 1, 0, 32'h1000, 32'h8000);
    miss_en = 0;
    chk(np - p0 == 2, "R7", "closed entry lines skipped", np - p0, 2);
    chk(plog_a[p0 % 64] == 32'h8000, "R6", "first probe", plog_a[p0 % 64], 32'h8000);
    chk(plog_a[(p0+1) % 64] == 32'h9180 && plog_s[(p0+1) % 64], "R1", "second probe addr/secure",
        {plog_s[(p0+1) % 64], plog_a[(p0+1) % 64]}, {1'b1, 32'h9180});
    chk(nq - q0 == 1, "R7", "one pattern", nq - q0, 1);
    chk(qk[q0 % 16] == 24'h1100, "R7", "pattern key", qk[q0 % 16], 24'h1100);
    chk(ql[q0 % 16] == 4'b1011, "R4", "line mask", ql[q0 % 16], 4'b1011);
    chk(qd[q0 % 16] == 16'h1000, "R4", "gap counts", qd[q0 % 16], 16'h1000);

    miss_all = 1; q0 = nq;
    access(16'h30, 1, 0, 32'h1200, 32'hA000);
    miss_all = 0;
    chk(nq - q0 == 2, "R10", "two closes", nq - q0, 2);
    chk(qk[q0 % 16] == 24'h2000 && ql[q0 % 16] == 4'b0001, "R10", "fresh generation",
        {qk[q0 % 16], ql[q0 % 16]}, {24'h2000, 4'b0001});
    chk(qk[(q0+1) % 16] == 24'h1302, "R7", "key with trigger offset", qk[(q0+1) % 16], 24'h1302);

    for (int k = 0; k < 20; k++) access(16'h40, 1, 0, 32'h1300, 32'hB000);
    access(16'h41, 1, 0, 32'h1240, 32'hA040);
    miss_all = 1; q0 = nq;
    access(16'h42, 1, 0, 32'h1500, 32'hC000);
    miss_all = 0;
    chk(qk[q0 % 16] == 24'h3000 && ql[q0 % 16] == 4'b0011, "R4", "appended line",
        {qk[q0 % 16], ql[q0 % 16]}, {24'h3000, 4'b0011});
    chk(qd[q0 % 16] == 16'h00F0, "R5", "saturated gap", qd[q0 % 16], 16'h00F0);

    do_reset();
    p0 = np; q0 = nq;
    access(16'h99, 0, 0, 32'h2000, 32'hD000);
    chk(!busy_seen && np == p0, "R2", "no-pc access ignored", {busy_seen, np - p0}, 0);
    access(16'hA1, 1, 0, 32'h2000, 32'hD000);
    access(16'hA2, 1, 0, 32'h2200, 32'hD200);
    access(16'hA3, 1, 0, 32'h2400, 32'hD400);
    access(16'hA4, 1, 0, 32'h2600, 32'hD600);
    access(16'hA5, 1, 0, 32'h2000, 32'hD000);
    access(16'hA6, 1, 0, 32'h2800, 32'hD800);
    chk(nq == q0, "R3", "replacement emits no pattern", nq - q0, 0);
    miss_all = 1;
    access(16'hB0, 1, 0, 32'h3100, 32'hE000);
    miss_all = 0;
    chk(nq - q0 == 4, "R3", "four closes", nq - q0, 4);
    chk(qk[q0 % 16] == 24'hA100, "R2", "way0 kept first pc", qk[q0 % 16], 24'hA100);
    chk(qk[(q0+1) % 16] == 24'hA600, "R3", "LRU way replaced", qk[(q0+1) % 16], 24'hA600);
    chk(qk[(q0+2) % 16] == 24'hA300 && qk[(q0+3) % 16] == 24'hA400, "R3", "other ways",
        {qk[(q0+2) % 16], qk[(q0+3) % 16]}, {24'hA300, 24'hA400});

    do_reset();
    @(negedge clk);
    chk(acc_ready && !probe_req && !pat_valid, "R9", "second reset", {acc_ready, probe_req, pat_valid}, 3'b100);
    p0 = np;
    access(16'h55, 1, 0, 32'h4000, 32'hF000);
    chk(np == p0, "R9", "table empty after reset", np - p0, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule